// File: doc/BRIEF.md
# Nibble-Shift Instruction Byte Encoder

This block turns one instruction into the byte stream read by a decoder that builds each instruction field four bits at a time. An instruction is an 8-bit opcode, an operand count from 0 to 2 and up to two 16-bit signed operands. It is captured with a start/ready handshake and then sent as a stream of 8-bit code bytes. The encoder picks the shortest byte sequence that rebuilds every field exactly.

The target decoder clears all fields before each instruction. For each byte it either shifts the nibble into the selected field, giving `{field[11:0], nibble}`, or, when the invert flag is set, gives `{~field[11:0], nibble}`. A negative operand can therefore be sent short. The first byte sets the invert flag, which turns the cleared upper bits into ones. Only as many low nibbles as the one's complement magnitude needs are sent, and always at least one. The nibble payloads are the operand's own low nibbles, so the value is rebuilt bit for bit.

The output follows valid/ready rules. A byte is transferred on a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, the presented byte, `out_last` and all internal progress hold unchanged. `in_ready` is high only when the encoder is idle. It is low from the cycle after a start is accepted until the final byte has been transferred.

Top module: `shenc_top`

## Requirements
- R1: Every emitted byte has bit 7 = more bytes follow, bit 6 = invert field before shifting, bits 5:4 = field selector, and bits 3:0 = the nibble to shift in. The selector values are 0 for the opcode, 2 for operand A and 3 for operand B. Selector 1 never appears.
- R2: All operand A bytes come first, then all operand B bytes, then the opcode bytes. Operand A is encoded only when the count is 1 or more, and operand B only when the count is 2. An operand beyond the count emits nothing, whatever its value.
- R3: A positive operand is sent as its significant nibbles, most significant first, with leading zero nibbles left out. Each byte is 0xAn for A or 0xBn for B. An operand equal to zero emits no bytes.
- R4: A negative operand v emits k bytes, where k is the number of significant nibbles of ~v and at least 1. The first byte is 0xEn for A or 0xFn for B, and the rest are plain. The payloads are nibbles k-1 down to 0 of v. The stream rebuilds v exactly under the decoder rule above. For example, -1 gives the single byte 0xEF on A.
- R5: A nonzero opcode high nibble is sent as 0x8n, followed by the final byte 0x0n that carries the low opcode nibble. An opcode of zero emits the single byte 0x00.
- R6: `out_last` is high together with `out_valid` on the final opcode byte and on no other byte. After that byte is transferred, `out_valid` is low and `in_ready` is high in the next cycle.
- R7: A start is accepted only when `in_valid` and `in_ready` are both high. A start with count 3 raises `in_err` in that same cycle and is dropped without emitting any byte. While the encoder is busy, `in_valid` and the instruction inputs are ignored.
- R8: While `out_valid` is high and `out_ready` is low, `out_byte` and `out_last` hold, and no byte is skipped or repeated.
- R9: A synchronous reset returns the encoder to idle, with `out_valid` low and `in_ready` high. This also holds in the middle of an instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Start request for one instruction |
| in_ready | output | 1 | Encoder idle, start will be taken |
| in_opcode | input | 8 | Opcode value |
| in_nops | input | 2 | Operand count (0 to 2; 3 is an error) |
| in_opa | input | 16 | Operand A, two's complement |
| in_opb | input | 16 | Operand B, two's complement |
| in_err | output | 1 | Start with count 3 was rejected this cycle |
| out_valid | output | 1 | A code byte is presented |
| out_ready | input | 1 | Consumer takes the byte this cycle |
| out_byte | output | 8 | Code byte |
| out_last | output | 1 | Presented byte ends the instruction |

## Verification
The hardest state to reach from the ports is a stall on the inverted first byte of a negative operand at a field boundary. This must happen while a new start request is already waiting at the input. The bench reaches it by holding `in_valid` high with fresh data while `out_ready` is driven low or randomly. It uses operands chosen near nibble edges, such as -1, -16, -17, 0x8000 and 0x0FFF. A reference decoder in the bench rebuilds every field from the emitted bytes and compares the result with the operands that were sent. A reset asserted during a stalled instruction checks that no partial stream survives.

// File: rtl/shenc_pkg.sv
package shenc_pkg;
  localparam int NIB_W = 4;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SEL_OPC = 2'd0,
    SEL_OPA = 2'd2,
    SEL_OPB = 2'd3
  } fsel_e;

  function automatic logic [BYTE_W-1:0] pack_code(input logic more, input logic inv,
                                                  input fsel_e sel, input logic [NIB_W-1:0] nib);
    return {more, inv, sel, nib};
  endfunction
endpackage

// File: rtl/shenc_span.sv
// Counts the nibbles a field needs; signed fields measure the one's complement
// magnitude when negative.
module shenc_span #(
  parameter int W = 16,
  parameter bit IS_SIGNED = 1'b1,
  parameter bit MIN_ONE = 1'b0,
  parameter int LW = $clog2(W / 4 + 1)
) (
  input  logic [W-1:0]  value,
  output logic [LW-1:0] len,
  output logic          neg
);
  localparam int NNIB = W / 4;
  logic [W-1:0] mag;

  always_comb begin
    neg = IS_SIGNED && value[W-1];
    mag = neg ? ~value : value;
    len = '0;
    for (int i = 0; i < NNIB; i++) begin
      if (mag[i*4 +: 4] != '0) len = LW'(i + 1);
    end
    if ((neg || MIN_ONE) && len == '0) len = LW'(1);
  end
endmodule

// File: rtl/shenc_seq.sv
// Walks the fields A, B, opcode and presents one code byte at a time.
module shenc_seq
  import shenc_pkg::*;
#(
  parameter int W = 16,
  parameter int NOPS = 2,
  parameter int LW = $clog2(W / 4 + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic [NOPS-1:0][W-1:0]    ld_val,
  input  logic [NOPS-1:0][LW-1:0]   ld_len,
  input  logic [NOPS-1:0]           ld_neg,
  input  logic [W-1:0]              ld_opc,
  input  logic [LW-1:0]             ld_olen,
  input  logic                      out_ready,
  output logic                      busy,
  output logic [BYTE_W-1:0]         code,
  output logic                      last
);
  localparam logic [1:0] FLD_A = 2'd0;
  localparam logic [1:0] FLD_B = 2'd1;
  localparam logic [1:0] FLD_O = 2'd2;

  logic [NOPS-1:0][W-1:0]  val_q;
  logic [NOPS-1:0][LW-1:0] len_q;
  logic [NOPS-1:0]         neg_q;
  logic [W-1:0]            opc_q;
  logic [LW-1:0]           olen_q;
  logic [1:0]              fld_q;
  logic [LW-1:0]           cnt_q;

  logic [W-1:0]  word;
  logic [LW-1:0] pos;
  logic          inv;
  fsel_e         sel;

  always_comb begin
    pos = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
    case (fld_q)
      FLD_A: begin
        sel = SEL_OPA; word = val_q[0]; inv = neg_q[0] && (cnt_q == len_q[0]);
      end
      FLD_B: begin
        sel = SEL_OPB; word = val_q[1]; inv = neg_q[1] && (cnt_q == len_q[1]);
      end
      default: begin
        sel = SEL_OPC; word = opc_q; inv = 1'b0;
      end
    endcase
    last = (fld_q == FLD_O) && (cnt_q == LW'(1));
    code = pack_code(!last, inv, sel, NIB_W'(word >> (NIB_W * pos)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      fld_q <= FLD_A;
      cnt_q <= '0;
    end else if (load) begin
      busy   <= 1'b1;
      val_q  <= ld_val;
      len_q  <= ld_len;
      neg_q  <= ld_neg;
      opc_q  <= ld_opc;
      olen_q <= ld_olen;
      if (ld_len[0] != '0) begin
        fld_q <= FLD_A; cnt_q <= ld_len[0];
      end else if (ld_len[1] != '0) begin
        fld_q <= FLD_B; cnt_q <= ld_len[1];
      end else begin
        fld_q <= FLD_O; cnt_q <= ld_olen;
      end
    end else if (busy && out_ready) begin
      if (cnt_q > LW'(1)) begin
        cnt_q <= cnt_q - 1'b1;
      end else begin
        case (fld_q)
          FLD_A: begin
            if (len_q[1] != '0) begin
              fld_q <= FLD_B; cnt_q <= len_q[1];
            end else begin
              fld_q <= FLD_O; cnt_q <= olen_q;
            end
          end
          FLD_B: begin
            fld_q <= FLD_O; cnt_q <= olen_q;
          end
          default: busy <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/shenc_top.sv
module shenc_top
  import shenc_pkg::*;
#(
  parameter int OPC_W = 8,
  parameter int OPND_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OPC_W-1:0]  in_opcode,
  input  logic [1:0]        in_nops,
  input  logic [OPND_W-1:0] in_opa,
  input  logic [OPND_W-1:0] in_opb,
  output logic              in_err,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_byte,
  output logic              out_last
);
  localparam int NOPS = 2;
  localparam int LW = $clog2(OPND_W / 4 + 1);

  logic [NOPS-1:0][OPND_W-1:0] opnds;
  logic [NOPS-1:0][LW-1:0]     span_len, used_len;
  logic [NOPS-1:0]             span_neg;
  logic [OPND_W-1:0]           opc_ext;
  logic [LW-1:0]               opc_len;
  logic                        opc_neg;
  logic                        busy, accept, load;

  assign opnds   = {in_opb, in_opa};
  assign opc_ext = {{(OPND_W - OPC_W){1'b0}}, in_opcode};

  for (genvar g = 0; g < NOPS; g++) begin : g_opnd
    shenc_span #(.W(OPND_W), .IS_SIGNED(1'b1), .MIN_ONE(1'b0), .LW(LW)) u_span (
      .value(opnds[g]), .len(span_len[g]), .neg(span_neg[g]));
    assign used_len[g] = (in_nops > 2'(g)) ? span_len[g] : '0;
  end

  shenc_span #(.W(OPND_W), .IS_SIGNED(1'b0), .MIN_ONE(1'b1), .LW(LW)) u_opc_span (
    .value(opc_ext), .len(opc_len), .neg(opc_neg));

  assign in_ready = !busy;
  assign accept   = in_valid && !busy;
  assign in_err   = accept && (in_nops == 2'd3);
  assign load     = accept && !in_err;

  shenc_seq #(.W(OPND_W), .NOPS(NOPS), .LW(LW)) u_seq (
    .clk(clk), .rst(rst), .load(load),
    .ld_val(opnds), .ld_len(used_len), .ld_neg(span_neg & ~{NOPS{opc_neg}}),
    .ld_opc(opc_ext), .ld_olen(opc_len),
    .out_ready(out_ready), .busy(busy), .code(out_byte), .last(out_last));

  assign out_valid = busy;
endmodule

// File: rtl/shenc_chk.sv
module shenc_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_ready,
  input logic       in_err,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_byte,
  input logic       out_last
);
  p_sel_legal_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_byte[5:4] != 2'd1);

  p_no_a_after_b_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_byte[5:4] == 2'd3 |=> !out_valid || out_byte[5:4] != 2'd2);

  p_last_is_opcode_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_last |-> out_byte[5:4] == 2'd0 && !out_byte[6]);

  p_idle_after_last_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_last |=> !out_valid && in_ready);

  p_busy_blocks_start_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  p_err_no_output_r7: assert property (@(posedge clk) disable iff (rst)
    in_err |=> !out_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_byte) && $stable(out_last));

  p_reset_idle_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid && in_ready);
endmodule

bind shenc_top shenc_chk u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .in_err(in_err),
  .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte), .out_last(out_last));

// File: tb/sim_shenc_top.sv
`timescale 1ns/1ps
module sim_shenc_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready, in_err;
  logic [7:0]  in_opcode = '0;
  logic [1:0]  in_nops = '0;
  logic [15:0] in_opa = '0, in_opb = '0;
  logic        out_valid, out_last;
  logic        out_ready = 1'b1;
  logic [7:0]  out_byte;

  always #2 clk = ~clk;

  shenc_top u0 (.*);

  int compared = 0, mismatched = 0;
  string cur_req = "R9";
  int rmode = 0;
  bit acc_flag = 0;

  logic [7:0]  expq[$];
  logic [15:0] exp_a, exp_b, exp_o, dec_a, dec_b, dec_o;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int sig_nibs(input logic [15:0] v);
    int n = 0;
    for (int i = 0; i < 4; i++) if (((v >> (4 * i)) & 16'hF) != 0) n = i + 1;
    return n;
  endfunction

  task automatic push_field(input logic [15:0] v, input logic [1:0] sel);
    bit neg;
    int n;
    if (v == 0) return;
    neg = v[15];
    n = neg ? sig_nibs(~v) : sig_nibs(v);
    if (neg && n == 0) n = 1;
    for (int i = n - 1; i >= 0; i--)
      expq.push_back({1'b1, (neg && i == n - 1), sel, 4'(v >> (4 * i))});
  endtask

  // reference model: expected stream and a reference decoder
  always @(posedge clk) begin
    if (rst) begin
      expq.delete();
    end else if (expq.size() != 0 && out_ready) begin
      logic [7:0] b;
      logic [15:0] f;
      b = expq.pop_front();
      case (b[5:4])
        2'd2: f = dec_a; 2'd3: f = dec_b; default: f = dec_o;
      endcase
      f = b[6] ? {~f[11:0], b[3:0]} : {f[11:0], b[3:0]};
      case (b[5:4])
        2'd2: dec_a = f; 2'd3: dec_b = f; default: dec_o = f;
      endcase
      if (expq.size() == 0) begin
        chk(dec_a == exp_a, "R4", "rebuilt A", dec_a, exp_a);
        chk(dec_b == exp_b, "R4", "rebuilt B", dec_b, exp_b);
        chk(dec_o == exp_o, "R5", "rebuilt opcode", dec_o, exp_o);
      end
    end else if (in_valid && expq.size() == 0 && in_nops != 2'd3) begin
      exp_a = (in_nops >= 1) ? in_opa : 16'h0;
      exp_b = (in_nops == 2) ? in_opb : 16'h0;
      exp_o = {8'h0, in_opcode};
      dec_a = 0; dec_b = 0; dec_o = 0;
      push_field(exp_a, 2'd2);
      push_field(exp_b, 2'd3);
      if (in_opcode[7:4] != 0) expq.push_back({4'h8, in_opcode[7:4]});
      expq.push_back({4'h0, in_opcode[3:0]});
      acc_flag = 1;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(out_valid == (expq.size() != 0), cur_req, "out_valid", out_valid, expq.size() != 0);
      chk(in_ready == (expq.size() == 0), "R7", "in_ready", in_ready, expq.size() == 0);
      chk(in_err == (in_valid && expq.size() == 0 && in_nops == 2'd3), "R7", "in_err",
          in_err, in_valid && expq.size() == 0 && in_nops == 2'd3);
      if (out_valid && expq.size() != 0) begin
        chk(out_byte == expq[0], cur_req, "out_byte", out_byte, expq[0]);
        chk(out_last == (expq.size() == 1), "R6", "out_last", out_last, expq.size() == 1);
        chk(out_byte[5:4] != 2'd1, "R1", "selector", out_byte[5:4], 2);
      end
    end
  end

  always begin
    @(posedge clk); #1;
    out_ready = (rmode == 0) ? 1'b1 : (rmode == 2) ? 1'b0 : 1'($urandom % 2);
  end

  task automatic send(input logic [7:0] opc, input logic [1:0] n, input logic [15:0] a, input logic [15:0] b);
    in_opcode = opc; in_nops = n; in_opa = a; in_opb = b;
    in_valid = 1; acc_flag = 0;
    do begin @(posedge clk); #1; end while (!acc_flag);
    in_valid = 0;
  endtask

  task automatic drain();
    while (expq.size() != 0) begin @(posedge clk); #1; end
    @(posedge clk); #1;
  endtask

  function automatic logic [15:0] pick();
    case ($urandom % 5)
      0: return 16'h0;
      1: return 16'(-($urandom % 40));
      2: return 16'($urandom % 300);
      3: return {$urandom % 2 ? 4'hF : 4'h0, 12'($urandom)};
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(!out_valid, "R9", "reset out_valid", out_valid, 0);
    chk(in_ready, "R9", "reset in_ready", in_ready, 1);
    @(posedge clk); #1;

    cur_req = "R5"; send(8'h00, 0, 0, 0); drain();
    send(8'h3C, 0, 0, 0); drain();
    send(8'h07, 0, 0, 0); drain();
    cur_req = "R3"; send(8'h12, 2, 16'h0012, 16'h0300); drain();
    send(8'h40, 2, 16'h0000, 16'h0000); drain();
    send(8'h41, 1, 16'hFFFF, 16'h0000); drain();
    cur_req = "R2"; send(8'h05, 1, 16'h0ABC, 16'h1234); drain();
    send(8'h06, 0, 16'h0ABC, 16'h1234); drain();
    cur_req = "R4"; send(8'h11, 2, 16'hFFFF, 16'hFFFE); drain();
    send(8'h22, 2, 16'h8000, 16'hFF00); drain();
    send(8'h33, 2, 16'hFFF0, 16'hFFEF); drain();
    send(8'h44, 2, 16'h0FFF, 16'h7FFF); drain();

    cur_req = "R7";
    in_opcode = 8'h99; in_nops = 2'd3; in_opa = 16'h5; in_opb = 16'h6; in_valid = 1;
    @(posedge clk); #1 in_valid = 0;
    @(negedge clk);
    chk(!out_valid, "R7", "count 3 emits nothing", out_valid, 0);
    @(posedge clk); #1;
    send(8'hA1, 2, 16'hFFF3, 16'h0042);
    send(8'hB2, 1, 16'h0777, 16'h0);
    drain();

    cur_req = "R8"; rmode = 2;
    send(8'hC3, 2, 16'hFFEE, 16'h0101);
    repeat (6) @(posedge clk);
    #1 rmode = 0; drain();

    cur_req = "R9"; rmode = 2;
    send(8'hD4, 2, 16'h1234, 16'hF00F);
    repeat (2) @(posedge clk);
    #1 rst = 1;
    @(posedge clk); #1 rst = 0; rmode = 0;
    @(negedge clk);
    chk(!out_valid && in_ready, "R9", "mid-stream reset idle", out_valid, 0);
    @(posedge clk); #1;

    cur_req = "R1"; rmode = 1;
    for (int k = 0; k < 300; k++) begin
      send(8'($urandom), 2'($urandom % 3), pick(), pick());
      if ($urandom % 3 == 0) drain();
    end
    rmode = 0; drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule